// File: doc/BRIEF.md
# Error-Triggered Page Repair Sequencer

This controller sits beside a resistive memory array whose cells each hold a dormant spare device in the same stack. It watches two streams of per-word error counts. One stream is the exact count that the write-verify logic reports after a write. The other is the count that the read-side ECC detects. When a word carries more failed bits than the code can correct, the controller repairs it.

Repair escalates in two steps. While the row-remapping unit still has free spare rows, the controller issues a single remap request for the failing word. Once that unit reports that no spare rows remain, the controller walks every word of the failing page in turn. For each word it reads the contents into a holding register, fires the strong activation pulse that hands the cell over to its spare device, and writes the held value back. The write-back goes through a polarity encoder that is already set to the spare's polarity. After the last word, the controller marks the page's polarity bit as flipped and clears that page's remap entries.

A page may be switched to its spares only once. An uncorrectable event on an already-switched page, arriving while no spare rows are left, raises a sticky fatal flag.

Top module: `rps_seq`

## Requirements
- R1: A report triggers repair only when its count is strictly greater than the correction limit `CORR_T` (default 1). A report whose count is at or below the limit produces no output activity.
- R2: Both report sources are honoured, and a read-side count may be larger than the limit. When both sources report an uncorrectable count in the same cycle, the write-verify report is acted on and the read report is discarded.
- R3: If `remap_exhausted` is low when an uncorrectable report is accepted, `remap_req` pulses for exactly one cycle, one cycle after the report, with `remap_addr` equal to the reported address. No sweep follows.
- R4: If `remap_exhausted` is high when the report is accepted and the page has not been switched before, a sweep starts one cycle later. The sweep covers words 0 to `WORDS-1` of the reported page in ascending order. Each word takes three consecutive cycles: a read, then an activation at the same address, then a write-back at the same address. Memory read data is expected one cycle after `mem_rd_en`. The memory address is `{page, word}`, with the page in the upper `PAGE_W` bits.
- R5: The cycle after the last write-back, `pol_wr_en` and `remap_clr` pulse together for one cycle, with `pol_wr_val` = 1 and with `pol_wr_page` and `remap_clr_page` equal to the swept page. One idle-bound cycle follows, and then the block accepts reports again.
- R6: Each page is swept at most once. An uncorrectable report for an already-swept page while `remap_exhausted` is high starts no sweep and sets `fatal` one cycle later. `fatal` stays set until reset. Remap requests for such a page are still issued while spare rows remain.
- R7: `busy` is high from the first read of a sweep through the cycle after the polarity update. Reports that arrive while the block is not idle are dropped and never acted on.
- R8: The write-back data of every word is the bitwise inverse of the data read for that word, which is the encoding for the spare device's polarity.
- R9: After reset all strobes are low, `busy` and `fatal` are low, and no page is marked as swept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wv_valid | input | 1 | Write-verify error report valid |
| wv_count | input | CNT_W | Exact failed-bit count from write verify |
| wv_addr | input | ADDR_W | Word address of the write-verify report |
| ecc_valid | input | 1 | Read ECC error report valid |
| ecc_count | input | CNT_W | Failed-bit count detected by ECC |
| ecc_addr | input | ADDR_W | Word address of the ECC report |
| remap_exhausted | input | 1 | High when no spare rows remain |
| remap_req | output | 1 | Request to remap one word to a spare row |
| remap_addr | output | ADDR_W | Address to remap |
| remap_clr | output | 1 | Clear all remap entries of a page |
| remap_clr_page | output | PAGE_W | Page whose remap entries are cleared |
| mem_rd_en | output | 1 | Array read strobe |
| mem_act_en | output | 1 | Spare activation pulse strobe |
| mem_wr_en | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array word address |
| mem_wdata | output | DATA_W | Polarity-encoded write-back data |
| mem_rdata | input | DATA_W | Array read data, one cycle after the read strobe |
| pol_wr_en | output | 1 | Polarity-bit write strobe |
| pol_wr_page | output | PAGE_W | Page whose polarity bit is written |
| pol_wr_val | output | 1 | New polarity-bit value |
| busy | output | 1 | Sweep in progress |
| fatal | output | 1 | Sticky unrepairable-page flag |

## Verification
Each response has a fixed latency after the cycle in which a report is sampled:
- A remap request appears one cycle later.
- A fatal flag appears one cycle later.
- A sweep's first read appears one cycle later.
- Activation and write-back follow their read by one and two cycles.
- The polarity update comes 3·`WORDS`+1 cycles after the report.

A driver pushes every expected strobe, with its address and data, into an ordered queue before it applies the report. A monitor samples on the falling edge and pops one item for every strobe it sees. Any extra, missing, reordered or wrongly addressed event therefore shows up as a mismatch. Drop and fatal cases are checked by confirming that no strobe appeared and by reading `busy` and `fatal` at their due cycle.

// File: rtl/rps_pkg.sv
package rps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REMAP,
        ST_READ,
        ST_ACT,
        ST_WB,
        ST_UPDATE,
        ST_DONE
    } rps_state_e;
endpackage

// File: rtl/rps_trigger.sv
module rps_trigger #(
    parameter int ADDR_W = 13,
    parameter int CNT_W  = 3,
    parameter int CORR_T = 1
) (
    input  logic              wv_valid,
    input  logic [CNT_W-1:0]  wv_count,
    input  logic [ADDR_W-1:0] wv_addr,
    input  logic              ecc_valid,
    input  logic [CNT_W-1:0]  ecc_count,
    input  logic [ADDR_W-1:0] ecc_addr,
    output logic              hit,
    output logic [ADDR_W-1:0] hit_addr
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CORR_T);

    logic wv_bad;
    logic ecc_bad;

    always_comb begin
        wv_bad   = wv_valid && (wv_count > LIMIT);
        ecc_bad  = ecc_valid && (ecc_count > LIMIT);
        hit      = wv_bad || ecc_bad;
        // write-verify report takes precedence
        hit_addr = wv_bad ? wv_addr : ecc_addr;
    end
endmodule

// File: rtl/rps_pol_enc.sv
module rps_pol_enc #(
    parameter int DATA_W = 16
) (
    input  logic              spare_pol,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dout[i] = din[i] ^ spare_pol;
    end
endmodule

// File: rtl/rps_seq.sv
module rps_seq
    import rps_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PAGES  = 8,
    parameter int WORDS  = 1024,
    parameter int CNT_W  = 3,
    parameter int CORR_T = 1,
    localparam int PAGE_W = $clog2(PAGES),
    localparam int WORD_W = $clog2(WORDS),
    localparam int ADDR_W = PAGE_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wv_valid,
    input  logic [CNT_W-1:0]  wv_count,
    input  logic [ADDR_W-1:0] wv_addr,
    input  logic              ecc_valid,
    input  logic [CNT_W-1:0]  ecc_count,
    input  logic [ADDR_W-1:0] ecc_addr,
    input  logic              remap_exhausted,
    output logic              remap_req,
    output logic [ADDR_W-1:0] remap_addr,
    output logic              remap_clr,
    output logic [PAGE_W-1:0] remap_clr_page,
    output logic              mem_rd_en,
    output logic              mem_act_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              pol_wr_en,
    output logic [PAGE_W-1:0] pol_wr_page,
    output logic              pol_wr_val,
    output logic              busy,
    output logic              fatal
);
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS - 1);

    typedef struct packed {
        rps_state_e        st;
        logic [PAGE_W-1:0] page;
        logic [WORD_W-1:0] word;
        logic [DATA_W-1:0] held;
        logic [PAGES-1:0]  swept;
        logic              fatal;
        logic [ADDR_W-1:0] tgt;
    } rps_regs_t;

    rps_regs_t r_q;
    rps_regs_t r_d;

    logic              hit;
    logic [ADDR_W-1:0] hit_addr;
    logic [PAGE_W-1:0] hit_page;

    rps_trigger #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .CORR_T (CORR_T)
    ) u_trig (
        .wv_valid  (wv_valid),
        .wv_count  (wv_count),
        .wv_addr   (wv_addr),
        .ecc_valid (ecc_valid),
        .ecc_count (ecc_count),
        .ecc_addr  (ecc_addr),
        .hit       (hit),
        .hit_addr  (hit_addr)
    );

    rps_pol_enc #(
        .DATA_W (DATA_W)
    ) u_enc (
        .spare_pol (1'b1),
        .din       (r_q.held),
        .dout      (mem_wdata)
    );

    assign hit_page = hit_addr[ADDR_W-1:WORD_W];

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (hit) begin
                    if (!remap_exhausted) begin
                        r_d.st  = ST_REMAP;
                        r_d.tgt = hit_addr;
                    end else if (r_q.swept[hit_page]) begin
                        r_d.fatal = 1'b1;
                    end else begin
                        r_d.st   = ST_READ;
                        r_d.page = hit_page;
                        r_d.word = '0;
                    end
                end
            end
            ST_REMAP:  r_d.st = ST_IDLE;
            ST_READ:   r_d.st = ST_ACT;
            ST_ACT: begin
                r_d.held = mem_rdata;
                r_d.st   = ST_WB;
            end
            ST_WB: begin
                if (r_q.word == LAST_WORD) begin
                    r_d.st = ST_UPDATE;
                end else begin
                    r_d.word = r_q.word + 1'b1;
                    r_d.st   = ST_READ;
                end
            end
            ST_UPDATE: begin
                r_d.swept[r_q.page] = 1'b1;
                r_d.st              = ST_DONE;
            end
            ST_DONE:   r_d.st = ST_IDLE;
            default:   r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign remap_req      = (r_q.st == ST_REMAP);
    assign remap_addr     = r_q.tgt;
    assign remap_clr      = (r_q.st == ST_UPDATE);
    assign remap_clr_page = r_q.page;
    assign mem_rd_en      = (r_q.st == ST_READ);
    assign mem_act_en     = (r_q.st == ST_ACT);
    assign mem_wr_en      = (r_q.st == ST_WB);
    assign mem_addr       = {r_q.page, r_q.word};
    assign pol_wr_en      = (r_q.st == ST_UPDATE);
    assign pol_wr_page    = r_q.page;
    assign pol_wr_val     = 1'b1;
    assign busy           = (r_q.st == ST_READ) || (r_q.st == ST_ACT) || (r_q.st == ST_WB)
                         || (r_q.st == ST_UPDATE) || (r_q.st == ST_DONE);
    assign fatal          = r_q.fatal;
endmodule

// File: rtl/rps_seq_chk.sv
module rps_seq_chk #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              remap_exhausted,
    input logic              remap_req,
    input logic              remap_clr,
    input logic [PAGE_W-1:0] remap_clr_page,
    input logic              mem_rd_en,
    input logic              mem_act_en,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              pol_wr_en,
    input logic [PAGE_W-1:0] pol_wr_page,
    input logic              pol_wr_val,
    input logic              busy,
    input logic              fatal
);
    p_sweep_needs_exhausted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(remap_exhausted));

    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_en, mem_act_en, mem_wr_en, remap_req}));

    p_act_follows_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_act_en |-> ($past(mem_rd_en) && mem_addr == $past(mem_addr)));

    p_wb_follows_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_act_en) && mem_addr == $past(mem_addr)));

    p_pol_with_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pol_wr_en |-> (remap_clr && pol_wr_val && remap_clr_page == pol_wr_page));

    p_pol_after_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pol_wr_en |-> $past(mem_wr_en));

    p_fatal_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);

    p_strobes_in_sweep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_act_en || mem_wr_en || pol_wr_en) |-> busy);
endmodule

bind rps_seq rps_seq_chk #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .remap_exhausted (remap_exhausted),
    .remap_req       (remap_req),
    .remap_clr       (remap_clr),
    .remap_clr_page  (remap_clr_page),
    .mem_rd_en       (mem_rd_en),
    .mem_act_en      (mem_act_en),
    .mem_wr_en       (mem_wr_en),
    .mem_addr        (mem_addr),
    .pol_wr_en       (pol_wr_en),
    .pol_wr_page     (pol_wr_page),
    .pol_wr_val      (pol_wr_val),
    .busy            (busy),
    .fatal           (fatal)
);

// File: tb/rps_seq_tb.sv
module rps_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int PAGES  = 8;
    localparam int WORDS  = 1024;
    localparam int CNT_W  = 3;
    localparam int CORR_T = 1;
    localparam int PAGE_W = $clog2(PAGES);
    localparam int WORD_W = $clog2(WORDS);
    localparam int ADDR_W = PAGE_W + WORD_W;

    localparam int K_REMAP = 0;
    localparam int K_RD    = 1;
    localparam int K_ACT   = 2;
    localparam int K_WR    = 3;
    localparam int K_POL   = 4;

    typedef struct {
        int                kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        string             req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wv_valid = 1'b0;
    logic [CNT_W-1:0] wv_count = '0;
    logic [ADDR_W-1:0] wv_addr = '0;
    logic ecc_valid = 1'b0;
    logic [CNT_W-1:0] ecc_count = '0;
    logic [ADDR_W-1:0] ecc_addr = '0;
    logic remap_exhausted = 1'b0;
    logic remap_req, remap_clr, mem_rd_en, mem_act_en, mem_wr_en;
    logic pol_wr_en, pol_wr_val, busy, fatal;
    logic [ADDR_W-1:0] remap_addr, mem_addr;
    logic [PAGE_W-1:0] remap_clr_page, pol_wr_page;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;

    int tests = 0;
    int failed = 0;
    int events = 0;
    bit fin = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rps_seq #(
        .DATA_W (DATA_W), .PAGES (PAGES), .WORDS (WORDS),
        .CNT_W (CNT_W), .CORR_T (CORR_T)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .wv_valid (wv_valid), .wv_count (wv_count), .wv_addr (wv_addr),
        .ecc_valid (ecc_valid), .ecc_count (ecc_count), .ecc_addr (ecc_addr),
        .remap_exhausted (remap_exhausted),
        .remap_req (remap_req), .remap_addr (remap_addr),
        .remap_clr (remap_clr), .remap_clr_page (remap_clr_page),
        .mem_rd_en (mem_rd_en), .mem_act_en (mem_act_en), .mem_wr_en (mem_wr_en),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .pol_wr_en (pol_wr_en), .pol_wr_page (pol_wr_page), .pol_wr_val (pol_wr_val),
        .busy (busy), .fatal (fatal)
    );

    function automatic logic [DATA_W-1:0] word_val(input logic [ADDR_W-1:0] a);
        logic [31:0] m;
        m = 32'(a) * 32'd40503;
        return m[DATA_W-1:0] ^ 16'h5A5A;
    endfunction

    // array model: one cycle read latency
    always @(posedge clk) if (mem_rd_en) mem_rdata <= word_val(mem_addr);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic got(input int kind, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        exp_t e;
        events++;
        if (sb.size() == 0) begin
            check(1'b0, "R7", "unexpected strobe kind", kind, -1);
        end else begin
            e = sb.pop_front();
            check(e.kind == kind && e.addr == a && e.data == d, e.req,
                  $sformatf("event kind %0d/%0d addr", kind, e.kind), {a, d}, {e.addr, e.data});
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            if (remap_req)  got(K_REMAP, remap_addr, '0);
            if (mem_rd_en)  got(K_RD, mem_addr, '0);
            if (mem_act_en) got(K_ACT, mem_addr, '0);
            if (mem_wr_en)  got(K_WR, mem_addr, mem_wdata);
            if (pol_wr_en)  got(K_POL, ADDR_W'(pol_wr_page),
                                {14'b0, remap_clr && remap_clr_page == pol_wr_page, pol_wr_val});
        end
    end

    task automatic push(input int kind, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input string req);
        exp_t e;
        e.kind = kind; e.addr = a; e.data = d; e.req = req;
        sb.push_back(e);
    endtask

    task automatic push_sweep(input logic [PAGE_W-1:0] pg);
        for (int w = 0; w < WORDS; w++) begin
            logic [ADDR_W-1:0] a;
            a = {pg, WORD_W'(w)};
            push(K_RD, a, '0, "R4");
            push(K_ACT, a, '0, "R4");
            push(K_WR, a, ~word_val(a), "R8");
        end
        push(K_POL, ADDR_W'(pg), 16'd3, "R5");
    endtask

    task automatic report(input bit from_wv, input int cnt, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        if (from_wv) begin
            wv_valid = 1'b1; wv_count = CNT_W'(cnt); wv_addr = a;
        end else begin
            ecc_valid = 1'b1; ecc_count = CNT_W'(cnt); ecc_addr = a;
        end
        @(negedge clk);
        wv_valid = 1'b0; ecc_valid = 1'b0;
    endtask

    task automatic wait_sweep_end();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            tests++; failed++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!busy && !fatal && !remap_req && !mem_rd_en && !mem_act_en && !mem_wr_en
              && !pol_wr_en && !remap_clr, "R9", "reset outputs", {busy, fatal}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: count equal to limit is ignored
        snap = events;
        report(1'b1, CORR_T, {3'd1, 10'd7});
        repeat (5) @(negedge clk);
        check(events == snap && !busy, "R1", "no action at limit", events - snap, 0);

        // R1/R3: write-verify count above limit -> remap
        push(K_REMAP, {3'd2, 10'd5}, '0, "R3");
        report(1'b1, CORR_T + 1, {3'd2, 10'd5});
        check(remap_req && remap_addr == {3'd2, 10'd5}, "R3", "remap one cycle after",
              remap_req, 1);
        repeat (3) @(negedge clk);
        check(!busy, "R3", "no sweep while spares remain", busy, 0);

        // R2: read-side count above limit -> remap
        push(K_REMAP, {3'd6, 10'd1023}, '0, "R2");
        report(1'b0, 5, {3'd6, 10'd1023});
        repeat (3) @(negedge clk);

        // R2: both sources at once, write-verify wins
        push(K_REMAP, {3'd4, 10'd100}, '0, "R2");
        @(negedge clk);
        wv_valid = 1'b1; wv_count = 3'd4; wv_addr = {3'd4, 10'd100};
        ecc_valid = 1'b1; ecc_count = 3'd6; ecc_addr = {3'd7, 10'd3};
        @(negedge clk);
        wv_valid = 1'b0; ecc_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2", "single remap for dual report", sb.size(), 0);

        // R4/R5/R8: sweep of page 3
        remap_exhausted = 1'b1;
        push_sweep(3'd3);
        report(1'b0, 4, {3'd3, 10'd17});
        check(busy == 1'b1, "R7", "busy one cycle after report", busy, 1);
        repeat (60) @(negedge clk);
        // R7: report during sweep dropped
        report(1'b1, 7, {3'd5, 10'd9});
        check(busy == 1'b1, "R7", "busy mid sweep", busy, 1);
        wait_sweep_end();
        check(sb.size() == 0 && !busy && !fatal, "R5", "sweep fully observed",
              sb.size(), 0);

        // R6: second uncorrectable event on swept page -> fatal
        snap = events;
        report(1'b1, 2, {3'd3, 10'd40});
        check(fatal == 1'b1 && !busy, "R6", "fatal on swept page", fatal, 1);
        repeat (4) @(negedge clk);
        check(events == snap && fatal, "R6", "no resweep, fatal sticky", events - snap, 0);

        // R6: swept page still remaps while spares remain
        remap_exhausted = 1'b0;
        push(K_REMAP, {3'd3, 10'd41}, '0, "R6");
        report(1'b1, 3, {3'd3, 10'd41});
        repeat (3) @(negedge clk);

        // R4: a different page can still be swept
        remap_exhausted = 1'b1;
        push_sweep(3'd5);
        report(1'b1, 2, {3'd5, 10'd0});
        wait_sweep_end();
        check(sb.size() == 0 && fatal, "R4", "second page sweep", sb.size(), 0);

        fin = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule